// File: doc/BRIEF.md
# Synchronous Character Receiver with Sync Hunt

This block receives a serial bit stream, one bit for each cycle in which the bit strobe is high. After reset it is in hunt. In hunt it watches a sliding window of the most recent bits and waits for a configured sync pattern. The pattern can be one 8-bit character or a 16-bit pair. In a third mode the hunt ends on an external sync pulse instead of a pattern. Once it locks, the block builds characters of a selectable length, 5 to 8 bits, and presents each one right-justified on a parallel output with a one-cycle valid strobe.

The lock holds until one of these events: reset, clearing of the receive enable, loss of carrier while automatic enables are on, or a re-hunt command. Received characters that equal the sync pattern can be withheld from the output. A serial CRC-16 runs over the received data bits while its enable is set. A nonzero remainder raises an error flag, which means a block is in error once its two check bytes have arrived.

Top module: `sync_hunt_rx`

## Requirements
- R1: After reset, `hunting` is 1, `char_valid` is 0 and `crc_err` is 0.
- R2: With `sync_mode`=00, the receiver leaves hunt on the bit strobe at which the last 8 received bits, taken LSB first, equal `sync_b`.
- R3: With `sync_mode`=01, the receiver leaves hunt only when the last 16 received bits are `sync_a` followed by `sync_b`, each LSB first. `sync_b` alone does not end the hunt.
- R4: With `sync_mode`=11, no pattern is compared, and the hunt ends on a bit strobe at which `ext_sync` is 1.
- R5: Character length comes from `char_len`: 00 gives 5 bits, 10 gives 6, 01 gives 7 and 11 gives 8. The first character starts with the bit that follows the lock. Characters are assembled LSB first and output right-justified with zeros above.
- R6: `char_valid` is high for exactly one cycle, in the cycle after the strobe that carries a character's last bit. It is never high for a bit that arrived during hunt.
- R7: When `sync_inhibit` is 1, a character equal to `sync_b` is not delivered. In 16-bit mode, a character equal to `sync_a` is not delivered either. Other characters are delivered.
- R8: A cycle with `enter_hunt` high returns the receiver to hunt, and no character is delivered until the next lock.
- R9: While `rx_enable` is 0, the receiver is held in hunt and delivers nothing.
- R10: When `auto_en` is 1, `carrier` low acts as `rx_enable` low. When `auto_en` is 0, `carrier` has no effect.
- R11: The CRC (reflected polynomial 0xA001, initial value 0, bits fed in arrival order) restarts at each lock and takes in a received bit only while `crc_en` is 1. `crc_err` is 1 exactly when the remainder is nonzero, so it is 0 after data followed by its correct CRC (low byte first) and 1 after a wrong one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_en | input | 1 | Receive bit strobe |
| rx_data | input | 1 | Serial data |
| rx_enable | input | 1 | Receiver enable |
| enter_hunt | input | 1 | Re-hunt command |
| carrier | input | 1 | Carrier detect |
| auto_en | input | 1 | Carrier gates receiver |
| sync_inhibit | input | 1 | Withhold sync characters |
| crc_en | input | 1 | Feed bits into CRC |
| sync_mode | input | 2 | 00 8-bit, 01 16-bit, 11 external, 10 no lock |
| char_len | input | 2 | Character length code |
| sync_a | input | 8 | First sync character |
| sync_b | input | 8 | Second sync character (8-bit pattern) |
| ext_sync | input | 1 | External sync pulse |
| char_out | output | 8 | Received character, right-justified |
| char_valid | output | 1 | One-cycle character strobe |
| hunting | output | 1 | Receiver is in hunt |
| crc_err | output | 1 | CRC remainder nonzero |

## Verification
The assertions check four things on every cycle. The valid strobe is a single-cycle pulse and never follows a hunt cycle. The bit counter stays below the character length. A disable, a carrier drop under automatic enables, or a re-hunt command always puts the receiver in hunt on the next cycle. Pattern alignment, the exact bit order of each length code, and the suppression of sync characters can only be shown by the bench's scenarios, as can the CRC residue after correct and corrupted check bytes. The bench sweeps every character value at every length, in both pattern modes.

// File: rtl/sync_hunt_rx.sv
module sync_hunt_rx (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bit_en,
  input  logic       rx_data,
  input  logic       rx_enable,
  input  logic       enter_hunt,
  input  logic       carrier,
  input  logic       auto_en,
  input  logic       sync_inhibit,
  input  logic       crc_en,
  input  logic [1:0] sync_mode,
  input  logic [1:0] char_len,
  input  logic [7:0] sync_a,
  input  logic [7:0] sync_b,
  input  logic       ext_sync,
  output logic [7:0] char_out,
  output logic       char_valid,
  output logic       hunting,
  output logic       crc_err
);
  logic [15:0] win, crc;
  logic [7:0]  acc;
  logic [3:0]  cnt;

  wire         active  = rx_enable && !(auto_en && !carrier);
  wire [3:0]   len     = 4'd5 + {2'b00, char_len[0], char_len[1]};
  wire [15:0]  win_n   = {rx_data, win[15:1]};
  wire [7:0]   acc_n   = {rx_data, acc[7:1]};
  wire [7:0]   chr     = acc_n >> (4'd8 - len);
  wire [7:0]   mask    = 8'hFF >> (4'd8 - len);
  wire         is_sync = (chr == (sync_b & mask)) ||
                         (sync_mode == 2'b01 && chr == (sync_a & mask));
  wire         fb      = crc[0] ^ rx_data;
  wire [15:0]  crc_n   = {1'b0, crc[15:1]} ^ (fb ? 16'hA001 : 16'h0000);

  logic match;
  always_comb begin
    case (sync_mode)
      2'b00:   match = (win_n[15:8] == sync_b);
      2'b01:   match = (win_n == {sync_b, sync_a});
      2'b11:   match = ext_sync;
      default: match = 1'b0;
    endcase
  end

  assign crc_err = |crc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win <= '1; acc <= '0; cnt <= '0; crc <= '0;
      hunting <= 1'b1; char_out <= '0; char_valid <= 1'b0;
    end else begin
      char_valid <= 1'b0;
      if (!active || enter_hunt) begin
        hunting <= 1'b1;
        win     <= '1;
        cnt     <= '0;
      end else if (bit_en) begin
        if (hunting) begin
          win <= win_n;
          if (match) begin
            hunting <= 1'b0;
            cnt     <= '0;
            crc     <= '0;
          end
        end else begin
          acc <= acc_n;
          if (crc_en) crc <= crc_n;
          if (cnt == len - 4'd1) begin
            cnt <= '0;
            if (!(sync_inhibit && is_sync)) begin
              char_out   <= chr;
              char_valid <= 1'b1;
            end
          end else begin
            cnt <= cnt + 4'd1;
          end
        end
      end
    end
  end

  assert_valid_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    char_valid |=> !char_valid);
  assert_valid_after_lock_R6: assert property (@(posedge clk) disable iff (!rst_n)
    char_valid |-> !$past(hunting));
  assert_cnt_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < len);
  assert_rehunt_R8: assert property (@(posedge clk) disable iff (!rst_n)
    enter_hunt |=> hunting);
  assert_disable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_enable |=> (hunting && !char_valid));
  assert_carrier_loss_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_en && !carrier) |=> hunting);
endmodule

// File: tb/sim_sync_hunt_rx.sv
module sim_sync_hunt_rx;
  logic clk = 0, rst_n = 0;
  logic bit_en = 0, rx_data = 1, rx_enable = 1, enter_hunt = 0, carrier = 1;
  logic auto_en = 0, sync_inhibit = 0, crc_en = 0, ext_sync = 0;
  logic [1:0] sync_mode = 2'b00, char_len = 2'b11;
  logic [7:0] sync_a = 8'h68, sync_b = 8'h16;
  logic [7:0] char_out;
  logic char_valid, hunting, crc_err;

  int total = 0, bad = 0, vcnt = 0;
  logic [7:0] lastc;
  logic [15:0] mcrc;

  always #2 clk = ~clk;

  sync_hunt_rx u0 (.*);

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic sb(input logic b);
    @(negedge clk); rx_data = b; bit_en = 1;
    if (sync_mode == 2'b01 || sync_mode == 2'b00) mcrc = mcrc;
    @(negedge clk); bit_en = 0;
    if (char_valid) begin vcnt++; lastc = char_out; end
  endtask

  task automatic sch(input logic [7:0] v, input int n);
    for (int i = 0; i < n; i++) sb(v[i]);
  endtask

  task automatic crc_byte(input logic [7:0] v);
    for (int i = 0; i < 8; i++) begin
      logic f;
      f = mcrc[0] ^ v[i];
      mcrc = {1'b0, mcrc[15:1]} ^ (f ? 16'hA001 : 16'h0000);
    end
  endtask

  task automatic rehunt();
    @(negedge clk); rx_enable = 0; @(negedge clk); rx_enable = 1;
    sch(8'hFF, 8);
  endtask

  task automatic lock(input logic [1:0] m);
    sync_mode = m;
    rehunt();
    if (m == 2'b01) sch(sync_a, 8);
    sch(sync_b, 8);
  endtask

  initial begin
    #400000;
    bad++; total++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(hunting == 1 && char_valid == 0 && crc_err == 0, "R1 reset", {hunting, char_valid, crc_err}, 3'b100);
    rst_n = 1;

    // Sweep: both pattern modes, every length, every value
    for (int m = 0; m < 2; m++) begin
      for (int l = 0; l < 4; l++) begin
        int n;
        char_len = l[1:0];
        n = 5 + l[1] + 2 * l[0];
        sync_mode = m[1:0];
        rehunt();
        if (m == 1) begin
          sch(sync_b, 8);
          chk(hunting == 1, "R3 lone second char", hunting, 1);
          sch(sync_a, 8);
        end
        sch(sync_b, 8);
        chk(hunting == 0, m == 0 ? "R2 lock" : "R3 lock", hunting, 0);
        for (int v = 0; v < (1 << n); v++) begin
          vcnt = 0;
          for (int i = 0; i < n - 1; i++) sb(v[i]);
          chk(vcnt == 0, "R6 no early strobe", vcnt, 0);
          sb(v[n - 1]);
          chk(vcnt == 1 && lastc == v[7:0], "R5 char value", lastc, v);
          @(negedge clk);
          chk(char_valid == 0, "R6 single pulse", char_valid, 0);
        end
      end
    end

    // Sync inhibit
    char_len = 2'b11; sync_inhibit = 1;
    lock(2'b00);
    vcnt = 0; sch(sync_b, 8);
    chk(vcnt == 0, "R7 sync_b withheld", vcnt, 0);
    sch(8'h41, 8);
    chk(vcnt == 1 && lastc == 8'h41, "R7 other char", lastc, 8'h41);
    lock(2'b01);
    vcnt = 0; sch(sync_a, 8); sch(sync_b, 8);
    chk(vcnt == 0, "R7 both withheld 16-bit", vcnt, 0);
    sync_inhibit = 0;
    vcnt = 0; sch(sync_b, 8);
    chk(vcnt == 1 && lastc == sync_b, "R7 off delivers", lastc, sync_b);

    // External sync
    sync_mode = 2'b11; rehunt();
    sch(sync_b, 8);
    chk(hunting == 1, "R4 no pattern lock", hunting, 1);
    ext_sync = 1; sb(1'b0); ext_sync = 0;
    chk(hunting == 0, "R4 ext lock", hunting, 0);
    vcnt = 0; sch(8'hC3, 8);
    chk(vcnt == 1 && lastc == 8'hC3, "R4 char after ext", lastc, 8'hC3);

    // Re-hunt command
    lock(2'b00);
    sch(8'h5A, 3);
    @(negedge clk); enter_hunt = 1; @(negedge clk); enter_hunt = 0;
    chk(hunting == 1, "R8 hunting", hunting, 1);
    vcnt = 0; sch(8'h33, 8); sch(8'h77, 8);
    chk(vcnt == 0, "R8 no output", vcnt, 0);

    // Receive disable
    lock(2'b00);
    @(negedge clk); rx_enable = 0;
    vcnt = 0; sch(8'h99, 8);
    chk(hunting == 1 && vcnt == 0, "R9 disabled", vcnt, 0);
    rx_enable = 1;

    // Carrier
    lock(2'b00);
    carrier = 0; auto_en = 0;
    vcnt = 0; sch(8'h2D, 8);
    chk(hunting == 0 && vcnt == 1 && lastc == 8'h2D, "R10 carrier ignored", lastc, 8'h2D);
    auto_en = 1; @(negedge clk);
    chk(hunting == 1, "R10 carrier loss", hunting, 1);
    vcnt = 0; sch(8'h2D, 8);
    chk(vcnt == 0, "R10 no output", vcnt, 0);
    carrier = 1; auto_en = 0;

    // CRC
    lock(2'b00);
    crc_en = 1; mcrc = 0;
    for (int k = 0; k < 4; k++) begin sch(8'h11 * (k + 3), 8); crc_byte(8'h11 * (k + 3)); end
    sch(mcrc[7:0], 8); sch(mcrc[15:8], 8);
    chk(crc_err == 0, "R11 good crc", crc_err, 0);
    lock(2'b00);
    mcrc = 0;
    for (int k = 0; k < 4; k++) begin sch(8'h11 * (k + 3), 8); crc_byte(8'h11 * (k + 3)); end
    sch(mcrc[7:0] ^ 8'h01, 8); sch(mcrc[15:8], 8);
    chk(crc_err == 1, "R11 bad crc", crc_err, 1);
    lock(2'b00);
    chk(crc_err == 0, "R11 restart on lock", crc_err, 0);
    crc_en = 0; sch(8'hAA, 8);
    crc_en = 1; mcrc = 0;
    sch(8'h3C, 8); crc_byte(8'h3C);
    sch(mcrc[7:0], 8); sch(mcrc[15:8], 8);
    chk(crc_err == 0, "R11 excluded char", crc_err, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule